// File: doc/BRIEF.md
# Dual-Channel Performance Event Counter

This block gives a host bus two independent performance-monitoring channels. A bus monitor drives a vector of single-cycle event strobes into the block. Each channel holds a 6-bit event-select code that picks one strobe from that vector. Each cycle in which the picked strobe is high adds one to the channel's wrapping counter. Codes outside the defined groups are reserved and never count.

Each channel has an 8-bit response register. Its upper nibble holds two 2-bit mode codes:

- The pin mode decides when the channel pulses its own monitor output pin.
- The interrupt mode decides when the channel requests the shared interrupt.

Either action can happen on every counted event, or only at the cycle where the counter wraps to zero. A request sets a sticky per-channel cause flag. The active-low interrupt stays asserted while any flag is set, and software clears flags with a write-one-to-clear access.

Software reaches all state through a plain register port. Writes are single-cycle strobes and reads are combinational.

Top module: `perfmon_top`

## Requirements
- R1: After a synchronous active-low reset, every readable register is zero, both monitor pins are low and `irq_n` is high.
- R2: With a valid select code, each clock cycle in which the picked strobe is high raises that channel's counter by one; strobes not picked leave the counter unchanged. Valid codes map to strobe index (code − 16) and are 16..23, 24..30 and 32..35.
- R3: A reserved select code (any code outside 16..23, 24..30 and 32..35) never changes the counter, whatever strobes arrive.
- R4: The counter wraps from all ones to zero. A write to the counter register loads the written value, and it takes priority over an event in the same cycle; that event is not counted.
- R5: Pin mode 2 (response bits [5:4] = 2) makes the channel's monitor pin high for exactly the one cycle after each counted event.
- R6: Pin mode 3 makes the monitor pin high for exactly the one cycle after the counter wraps, and at no other time.
- R7: Pin modes 0 and 1 keep the monitor pin low.
- R8: Interrupt mode 2 (response bits [7:6] = 2) sets the channel's status flag on each counted event. Interrupt mode 3 sets it on a wrap. Modes 0 and 1 never set it. The flag is visible the cycle after the cause.
- R9: `irq_n` is low exactly while at least one status flag is set.
- R10: Status register (address 6, bit n = channel n) writes clear every flag whose data bit is 1 and leave flags whose bit is 0. A new cause in the same cycle as its clearing write keeps the flag set.
- R11: Register map: address 0/1 select code of channel 0/1, address 2/3 response register of channel 0/1, address 4/5 counter of channel 0/1, address 6 status. Each reads back what was written. The channels act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_strobe | input | 20 | Event strobes from the bus monitor, index = select code − 16 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| mon_pin | output | 2 | Per-channel monitor pins, bit n = channel n |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
The bench builds the block with a 4-bit counter, so a wrap is two events away from a preset of 14. The short counter makes the overflow-driven responses cheap to reach, so the bench can sweep all 16 combinations of pin mode and interrupt mode. It also sweeps all 64 select codes against each of the 20 strobe lines one at a time, which covers every valid and reserved code. Directed sequences cover the remaining corner cases:
- load-versus-event priority,
- a clear colliding with a new cause,
- writes of zero to the status register,
- independence between the two channels.

// File: rtl/perfmon_pkg.sv
// Shared constants, types and decode helpers for the performance counter.
// Assumes two channels and a 6-bit select code; the strobe vector index is
// the select code minus 16.
package perfmon_pkg;
    localparam int NCH    = 2;
    localparam int SEL_W  = 6;
    localparam int EV_W   = 20;
    localparam int IDX_W  = $clog2(EV_W);
    localparam int RESP_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [1:0] RGN_SEL  = 2'd0;
    localparam logic [1:0] RGN_RESP = 2'd1;
    localparam logic [1:0] RGN_CNT  = 2'd2;
    localparam logic [1:0] RGN_STAT = 2'd3;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 3'd6;

    typedef enum logic [1:0] {
        RM_OFF   = 2'd0,
        RM_RSVD  = 2'd1,
        RM_EVENT = 2'd2,
        RM_WRAP  = 2'd3
    } resp_mode_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } ev_pick_t;

    // Map a select code to a strobe index and flag reserved codes.
    function automatic ev_pick_t decode_sel(input logic [SEL_W-1:0] code);
        ev_pick_t p;
        p.idx   = IDX_W'(code - SEL_W'(16));
        p.valid = (code[5:3] == 3'b010) ||
                  (code[5:3] == 3'b011 && code[2:0] != 3'b111) ||
                  (code[5:2] == 4'b1000);
        return p;
    endfunction

    // Decide whether a response mode fires given this cycle's event and wrap.
    function automatic logic mode_fires(input resp_mode_e m, input logic ev,
                                        input logic wrap);
        case (m)
            RM_EVENT: return ev;
            RM_WRAP:  return wrap;
            default:  return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/perfmon_regs.sv
// Register file of the performance counter: select codes, response
// registers, counter load strobes, sticky cause flags and read-back mux.
// Assumes one write strobe per cycle and combinational reads; address bit 0
// picks the channel, bits [2:1] pick the register kind.
module perfmon_regs
    import perfmon_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NCH-1:0]                irq_req,
    input  logic [NCH-1:0][CNT_W-1:0]     cnt_q,
    output logic [NCH-1:0][SEL_W-1:0]     sel_q,
    output logic [NCH-1:0][RESP_W-1:0]    resp_q,
    output logic [NCH-1:0]                cnt_load,
    output logic [CNT_W-1:0]              load_val,
    output logic [NCH-1:0]                flags_q,
    output logic [DATA_W-1:0]             rdata
);
    logic [1:0] region;
    logic       ch_bit;
    logic       stat_wr;

    assign region   = addr[2:1];
    assign ch_bit   = addr[0];
    assign stat_wr  = wr_en && (addr == STAT_ADDR);
    assign load_val = wdata[CNT_W-1:0];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic hit_ch;
        logic clr_bit;

        assign hit_ch      = wr_en && (ch_bit == 1'(g));
        assign cnt_load[g] = hit_ch && (region == RGN_CNT);
        assign clr_bit     = stat_wr && wdata[g];

        // Hold the select code of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)                              sel_q[g] <= '0;
            else if (hit_ch && region == RGN_SEL)    sel_q[g] <= wdata[SEL_W-1:0];
        end

        // Hold the response register of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)                              resp_q[g] <= '0;
            else if (hit_ch && region == RGN_RESP)   resp_q[g] <= wdata[RESP_W-1:0];
        end

        // Sticky cause flag: a new request wins over a clearing write.
        always_ff @(posedge clk) begin
            if (!rst_n) flags_q[g] <= 1'b0;
            else        flags_q[g] <= irq_req[g] | (flags_q[g] & ~clr_bit);
        end

        assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[g] |=> flags_q[g]);
        assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[g] && !(wr_en && addr == STAT_ADDR && wdata[g])) |=> flags_q[g]);
        assert_flag_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == STAT_ADDR && wdata[g] && !irq_req[g]) |=> !flags_q[g]);
    end

    // Read-back multiplexer.
    always_comb begin
        rdata = '0;
        case (region)
            RGN_SEL:  rdata[SEL_W-1:0]  = sel_q[ch_bit];
            RGN_RESP: rdata[RESP_W-1:0] = resp_q[ch_bit];
            RGN_CNT:  rdata             = DATA_W'(cnt_q[ch_bit]);
            default:  if (!ch_bit) rdata[NCH-1:0] = flags_q;
        endcase
    end
endmodule

// File: rtl/perfmon_channel.sv
// One monitoring channel: picks a strobe by select code, counts it in a
// wrapping counter and produces the monitor pin pulse and interrupt request.
// Assumes a counter load from the register port takes priority over an event.
module perfmon_channel
    import perfmon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EV_W-1:0]  ev_strobe,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       pin_mode,
    input  logic [1:0]       irq_mode,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             pin_q,
    output logic             irq_req
);
    ev_pick_t pick;
    logic     hit;
    logic     counted;
    logic     wrap;

    assign pick    = decode_sel(sel);
    assign hit     = pick.valid && ev_strobe[pick.idx];
    assign counted = hit && !load;
    assign wrap    = counted && (cnt_q == '1);
    assign irq_req = mode_fires(resp_mode_e'(irq_mode), counted, wrap);

    // Event counter with load priority and natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (load)    cnt_q <= load_val;
        else if (counted) cnt_q <= cnt_q + 1'b1;
    end

    // One-cycle monitor pin pulse per the pin mode.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= mode_fires(resp_mode_e'(pin_mode), counted, wrap);
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !load) |=> cnt_q == $past(cnt_q) + 1'b1);
    assert_reserved_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!decode_sel(sel).valid && !load) |=> $stable(cnt_q));
    assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));
    assert_pin_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_mode[1] |=> !pin_q);
endmodule

// File: rtl/perfmon_top.sv
// Top of the dual-channel performance counter: register file, two channels
// and the shared active-low interrupt. Assumes a single clock domain and a
// synchronous active-low reset.
module perfmon_top
    import perfmon_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EV_W-1:0]   ev_strobe,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCH-1:0]    mon_pin,
    output logic              irq_n
);
    logic [NCH-1:0][SEL_W-1:0]  sel_q;
    logic [NCH-1:0][RESP_W-1:0] resp_q;
    logic [NCH-1:0][CNT_W-1:0]  cnt_q;
    logic [NCH-1:0]             cnt_load;
    logic [CNT_W-1:0]           load_val;
    logic [NCH-1:0]             irq_req;
    logic [NCH-1:0]             flags_q;

    perfmon_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .irq_req  (irq_req),
        .cnt_q    (cnt_q),
        .sel_q    (sel_q),
        .resp_q   (resp_q),
        .cnt_load (cnt_load),
        .load_val (load_val),
        .flags_q  (flags_q),
        .rdata    (reg_rdata)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        perfmon_channel #(.CNT_W(CNT_W)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev_strobe (ev_strobe),
            .sel       (sel_q[g]),
            .pin_mode  (resp_q[g][5:4]),
            .irq_mode  (resp_q[g][7:6]),
            .load      (cnt_load[g]),
            .load_val  (load_val),
            .cnt_q     (cnt_q[g]),
            .pin_q     (mon_pin[g]),
            .irq_req   (irq_req[g])
        );
    end

    assign irq_n = ~|flags_q;

    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |=> !irq_n);
    assert_irq_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == STAT_ADDR && (&reg_wdata[NCH-1:0]) && !(|irq_req))
        |=> irq_n);
endmodule

// File: tb/perfmon_top_tb_top.sv
// Self-checking bench: 4-bit counters, exhaustive select and response sweeps.
module perfmon_top_tb_top;
    localparam int CNT_W  = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [19:0]       ev_strobe = '0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [1:0]        mon_pin;
    logic              irq_n;

    int n_checks = 0;
    int n_errors = 0;
    int pin_cnt0 = 0;
    int pin_cnt1 = 0;

    always #4 clk = ~clk;

    perfmon_top #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mon_pin(mon_pin), .irq_n(irq_n)
    );

    always @(negedge clk) begin
        if (mon_pin[0]) pin_cnt0++;
        if (mon_pin[1]) pin_cnt1++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int j);
        ev_strobe = '0; ev_strobe[j] = 1'b1;
        @(negedge clk);
        ev_strobe = '0;
    endtask

    function automatic bit code_ok(input int c);
        return (c >= 16 && c <= 23) || (c >= 24 && c <= 30) || (c >= 32 && c <= 35);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register and output
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reg after reset", v, 0);
        end
        check("R1 irq_n after reset", 32'(irq_n), 1);
        check("R1 pins after reset", 32'(mon_pin), 0);

        // R2/R3: every select code against every single strobe line
        for (int c = 0; c < 64; c++) begin
            wr(3'd0, 32'(c));
            for (int j = 0; j < 20; j++) begin
                wr(3'd4, 0);
                pulse(j);
                rd(3'd4, v);
                if (code_ok(c))
                    check($sformatf("R2 code %0d strobe %0d", c, j), v, (c - 16 == j) ? 1 : 0);
                else
                    check($sformatf("R3 code %0d strobe %0d", c, j), v, 0);
            end
        end

        // R2: strobe held three cycles counts three
        wr(3'd0, 32'd35);
        wr(3'd4, 0);
        ev_strobe = '0; ev_strobe[19] = 1'b1;
        repeat (3) @(negedge clk);
        ev_strobe = '0;
        rd(3'd4, v);
        check("R2 held strobe", v, 3);

        // R4: load beats a same-cycle event
        ev_strobe[19] = 1'b1;
        wr(3'd4, 7);
        ev_strobe = '0;
        rd(3'd4, v);
        check("R4 load priority", v, 7);

        // R5: single event pulse timing on channel 0
        wr(3'd2, 32'h20);
        pin_cnt0 = 0;
        ev_strobe[19] = 1'b1;
        @(negedge clk);
        ev_strobe = '0;
        check("R5 pin high cycle after event", 32'(mon_pin[0]), 1);
        @(negedge clk);
        check("R5 pin one cycle only", 32'(mon_pin[0]), 0);
        wr(3'd2, 0);
        wr(3'd0, 0);

        // R5..R10: all pin/interrupt mode pairs on channel 1 across a wrap
        wr(3'd1, 32'd16);
        for (int r = 0; r < 16; r++) begin
            int pm = r % 4;
            int im = r / 4;
            wr(3'd3, 32'((im << 6) | (pm << 4)));
            wr(3'd6, 3);
            wr(3'd5, 14);
            pin_cnt0 = 0; pin_cnt1 = 0;
            pulse(0);
            pulse(0);
            @(negedge clk);
            check($sformatf("R5 R6 R7 pin pulses mode %0d", pm), pin_cnt1,
                  (pm == 2) ? 2 : (pm == 3) ? 1 : 0);
            check("R11 other channel pin quiet", pin_cnt0, 0);
            rd(3'd6, v);
            check($sformatf("R8 flag irq mode %0d", im), v, (im >= 2) ? 2 : 0);
            check("R9 irq_n level", 32'(irq_n), (im >= 2) ? 0 : 1);
            rd(3'd5, v);
            check("R4 wrap to zero", v, 0);
            wr(3'd6, 2);
            check("R10 clear releases irq", 32'(irq_n), 1);
        end

        // R8: wrap mode sets flag only at wrap, not on a plain event
        wr(3'd3, 32'hC0);
        wr(3'd5, 3);
        pulse(0);
        rd(3'd6, v);
        check("R8 no flag without wrap", v, 0);

        // R10: clear colliding with a new cause, and zero writes
        wr(3'd3, 32'h80);
        pulse(0);
        check("R9 irq asserted", 32'(irq_n), 0);
        ev_strobe[0] = 1'b1;
        wr(3'd6, 2);
        ev_strobe = '0;
        rd(3'd6, v);
        check("R10 set beats clear", v, 2);
        wr(3'd6, 0);
        rd(3'd6, v);
        check("R10 zero write keeps flag", v, 2);
        wr(3'd6, 1);
        rd(3'd6, v);
        check("R10 other bit keeps flag", v, 2);
        wr(3'd6, 2);
        rd(3'd6, v);
        check("R10 one write clears", v, 0);
        wr(3'd3, 0);

        // R11: independence and read-back
        wr(3'd0, 32'd16);
        wr(3'd1, 32'd24);
        wr(3'd2, 32'h5A);
        wr(3'd4, 0);
        wr(3'd5, 0);
        ev_strobe[0] = 1'b1;
        repeat (3) @(negedge clk);
        ev_strobe = '0;
        rd(3'd4, v); check("R11 ch0 counts", v, 3);
        rd(3'd5, v); check("R11 ch1 untouched", v, 0);
        rd(3'd0, v); check("R11 sel0 readback", v, 16);
        rd(3'd1, v); check("R11 sel1 readback", v, 24);
        rd(3'd2, v); check("R11 resp0 readback", v, 32'h5A);
        rd(3'd3, v); check("R11 resp1 readback", v, 0);
        rd(3'd6, v); check("R7 R8 reserved mode 1 no flag", v, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule